// File: doc/BRIEF.md
# Dual-FIFO synchronous serial port

This block is a word-oriented synchronous serial port in the SPI/Microwire family. It can run as bus master or as slave. Transmit and receive each have a 16-word by 16-bit FIFO and their own frame sync, so a frame can carry data in one direction only, or in both. The CPU writes words into the transmit FIFO with a push strobe. It reads the receive FIFO through a first-word-fall-through head with a pop strobe. Two level interrupts report the FIFO fill levels: the transmit side when it needs more data, the receive side when it holds enough to read.

In master mode the port starts a frame whenever the transmit FIFO holds a word. It generates the bit clock from the system clock, with a programmable half period. That half period has a hardware floor, so the serial clock never exceeds 512 kHz. In slave mode the bit clock and both frame syncs come from outside. They pass through two-flop synchronizers, and their edges drive the shifters. The `serOe` output tells the pad logic which way the clock and frame sync pins point.

Top module: `dual_fifo_ssp`

## Requirements
- R1: In master mode a frame starts only when the transmit FIFO is not empty. While it is empty, `sckOut`, `txFsOut` and `rxFsOut` stay low and no word is sent.
- R2: Words are shifted MSB first. `sckOut`/`sckIn` idles low. `txdOut` changes only after a falling clock edge, and received bits are taken on the rising edge. In master mode `txFsOut` is high for the whole 16-bit word.
- R3: In master mode each half period of `sckOut` lasts max(`clkDiv`, MINH) system cycles. MINH = ceil(SYS_HZ / (2 * 512000)), which is 4 at the default SYS_HZ of 4,096,000, so the bit clock never exceeds 512 kHz.
- R4: Each FIFO holds 16 words and delivers them in push order. Master frames run back to back while words remain.
- R5: `txHalfIrq` is high exactly while the transmit FIFO holds 8 or fewer words.
- R6: `rxHalfIrq` is high exactly while the receive FIFO holds 8 or more words.
- R7: A word completed while the receive FIFO is full is discarded, and the FIFO contents stay as they were. The event sets `ovrFlag`, which stays high until a one-cycle `ovrClr` pulse clears it.
- R8: In master mode `rxFsOut` is high during a frame only when `rxEn` is 1. Only then does the frame store its received word. With `rxEn` at 0 the receive FIFO stays unchanged.
- R9: In slave mode `serOe` is 0 and the port drives `sckOut`, `txFsOut` and `rxFsOut` low. A rising `txFsIn` loads the next transmit word. Falling `sckIn` edges shift it out. While `rxFsIn` is high, every 16 rising `sckIn` edges store one word. A frame with only `rxFsIn` high leaves `txdOut` low and the transmit FIFO untouched. In master mode `serOe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| masterMode | input | 1 | 1 selects master, 0 selects slave |
| rxEn | input | 1 | Master: assert receive frame sync and store received words |
| clkDiv | input | 8 | Requested half period of the master bit clock, in system cycles |
| txPush | input | 1 | Write `txData` into the transmit FIFO |
| txData | input | 16 | Word to transmit |
| txFull | output | 1 | Transmit FIFO full |
| rxPop | input | 1 | Remove the head word of the receive FIFO |
| rxData | output | 16 | Head word of the receive FIFO |
| rxEmpty | output | 1 | Receive FIFO empty |
| ovrClr | input | 1 | Clear the overrun flag |
| ovrFlag | output | 1 | Sticky receive overrun |
| txHalfIrq | output | 1 | Transmit FIFO at or below half |
| rxHalfIrq | output | 1 | Receive FIFO at or above half |
| sckOut | output | 1 | Bit clock driven in master mode |
| sckIn | input | 1 | Bit clock received in slave mode |
| txdOut | output | 1 | Serial data out |
| rxdIn | input | 1 | Serial data in |
| txFsOut | output | 1 | Transmit frame sync driven in master mode |
| txFsIn | input | 1 | Transmit frame sync received in slave mode |
| rxFsOut | output | 1 | Receive frame sync driven in master mode |
| rxFsIn | input | 1 | Receive frame sync received in slave mode |
| serOe | output | 1 | Output enable for the clock and both frame sync pins |

## Verification
The bench leaves the master idle with an empty FIFO. A port that sends a filler word there would toggle the clock. It programs divider values below the floor and measures the high phase of the clock. A missing clamp would run the bit clock faster than 512 kHz. It fills the receive FIFO past its depth and then reads back every word. A wrong overrun path would show up as an overwritten head or tail, or as a flag that clears itself. Receive-only slave frames and master frames with `rxEn` low check that one direction never moves data in the other. Writing 8 and then 9 words checks the exact thresholds of the half-level interrupts, where an off-by-one error would appear.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic loadTx;    // take next word into the transmit shifter
    logic shiftTx;   // advance transmit shifter by one bit
    logic sampleRx;  // capture one received bit
    logic pushRx;    // this capture completes a word
  } sspStrobes_t;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          doPush, doPop;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push & ~full;
  assign doPop  = pop & ~empty;
  assign rdata  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ssp_datapath.sv
module ssp_datapath
  import ssp_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  sspStrobes_t            st,
  input  logic                   txPush,
  input  logic [WORD_W-1:0]      txData,
  input  logic                   rxPop,
  input  logic                   ovrClr,
  input  logic                   rxdIn,
  output logic                   txdOut,
  output logic [WORD_W-1:0]      rxData,
  output logic                   txFull,
  output logic                   txEmpty,
  output logic                   rxEmpty,
  output logic [$clog2(DEPTH):0] txCnt,
  output logic [$clog2(DEPTH):0] rxCnt,
  output logic                   ovrFlag,
  output logic                   txHalfIrq,
  output logic                   rxHalfIrq
);
  localparam int CW   = $clog2(DEPTH) + 1;
  localparam int HALF = DEPTH / 2;

  logic [WORD_W-1:0] txHead, txShift, rxShift, rxWord;
  logic              rxFull, rxdMeta, rxdSync;

  ssp_fifo #(.W(WORD_W), .DEPTH(DEPTH)) txFifo_i (
    .clk(clk), .rstN(rstN), .push(txPush), .wdata(txData),
    .pop(st.loadTx), .rdata(txHead), .full(txFull), .empty(txEmpty),
    .count(txCnt)
  );

  ssp_fifo #(.W(WORD_W), .DEPTH(DEPTH)) rxFifo_i (
    .clk(clk), .rstN(rstN), .push(st.pushRx), .wdata(rxWord),
    .pop(rxPop), .rdata(rxData), .full(rxFull), .empty(rxEmpty),
    .count(rxCnt)
  );

  assign rxWord = {rxShift[WORD_W-2:0], rxdSync};
  assign txdOut = txShift[WORD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxdMeta <= 1'b0;
      rxdSync <= 1'b0;
      ovrFlag <= 1'b0;
    end else begin
      rxdMeta <= rxdIn;
      rxdSync <= rxdMeta;
      if (st.loadTx)       txShift <= txEmpty ? '0 : txHead;
      else if (st.shiftTx) txShift <= {txShift[WORD_W-2:0], 1'b0};
      if (st.sampleRx)     rxShift <= rxWord;
      if (st.pushRx && rxFull) ovrFlag <= 1'b1;
      else if (ovrClr)         ovrFlag <= 1'b0;
    end
  end

  assign txHalfIrq = (txCnt <= CW'(HALF));
  assign rxHalfIrq = (rxCnt >= CW'(HALF));
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int DIVW     = 8,
  parameter int MIN_HALF = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            masterMode,
  input  logic            rxEn,
  input  logic [DIVW-1:0] clkDiv,
  input  logic            txEmpty,
  input  logic            sckIn,
  input  logic            txFsIn,
  input  logic            rxFsIn,
  output sspStrobes_t     st,
  output logic            sckOut,
  output logic            txFsOut,
  output logic            rxFsOut
);
  localparam int BW = $clog2(WORD_W);
  localparam logic [DIVW-1:0] MINH = DIVW'(MIN_HALF);
  localparam logic [BW-1:0]   LAST = BW'(WORD_W - 1);

  // master timing
  logic [DIVW-1:0] halfLen, halfCnt;
  logic [BW-1:0]   mBit;
  logic            mActive, sckReg, mStart, mTick;
  sspStrobes_t     mSt, sSt;

  assign halfLen = (clkDiv < MINH) ? MINH : clkDiv;
  assign mStart  = ~mActive & ~txEmpty;
  assign mTick   = mActive & (halfCnt == halfLen - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mActive <= 1'b0;
      sckReg  <= 1'b0;
      halfCnt <= '0;
      mBit    <= '0;
    end else if (!masterMode) begin
      mActive <= 1'b0;
      sckReg  <= 1'b0;
      halfCnt <= '0;
      mBit    <= '0;
    end else if (mStart) begin
      mActive <= 1'b1;
      sckReg  <= 1'b0;
      halfCnt <= '0;
      mBit    <= '0;
    end else if (mTick) begin
      halfCnt <= '0;
      sckReg  <= ~sckReg;
      if (sckReg) begin
        mBit <= mBit + 1'b1;
        if (mBit == LAST) mActive <= 1'b0;
      end
    end else if (mActive) begin
      halfCnt <= halfCnt + 1'b1;
    end
  end

  always_comb begin
    mSt.loadTx   = mStart;
    mSt.shiftTx  = mTick & sckReg;
    mSt.sampleRx = mTick & ~sckReg & rxEn;
    mSt.pushRx   = mTick & ~sckReg & rxEn & (mBit == LAST);
  end

  // slave timing: two-flop synchronizers then edge detect
  logic [2:0]    syncMeta, syncQ;
  logic          sckPrev, txFsPrev;
  logic [BW-1:0] sRxBit;
  logic          sRise, sFall, txFsRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncMeta <= '0;
      syncQ    <= '0;
      sckPrev  <= 1'b0;
      txFsPrev <= 1'b0;
      sRxBit   <= '0;
    end else begin
      syncMeta <= {rxFsIn, txFsIn, sckIn};
      syncQ    <= syncMeta;
      sckPrev  <= syncQ[0];
      txFsPrev <= syncQ[1];
      if (masterMode || !syncQ[2]) sRxBit <= '0;
      else if (sRise)              sRxBit <= sRxBit + 1'b1;
    end
  end

  assign sRise    = syncQ[0] & ~sckPrev;
  assign sFall    = ~syncQ[0] & sckPrev;
  assign txFsRise = syncQ[1] & ~txFsPrev;

  always_comb begin
    sSt.loadTx   = txFsRise;
    sSt.shiftTx  = sFall & syncQ[1];
    sSt.sampleRx = sRise & syncQ[2];
    sSt.pushRx   = sRise & syncQ[2] & (sRxBit == LAST);
  end

  assign st      = masterMode ? mSt : sSt;
  assign sckOut  = masterMode & sckReg;
  assign txFsOut = masterMode & mActive;
  assign rxFsOut = masterMode & mActive & rxEn;
endmodule

// File: rtl/dual_fifo_ssp.sv
module dual_fifo_ssp
  import ssp_pkg::*;
#(
  parameter int SYS_HZ     = 4_096_000,
  parameter int MAX_SCK_HZ = 512_000,
  parameter int DIVW       = 8,
  parameter int DEPTH      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              rxEn,
  input  logic [DIVW-1:0]   clkDiv,
  input  logic              txPush,
  input  logic [WORD_W-1:0] txData,
  output logic              txFull,
  input  logic              rxPop,
  output logic [WORD_W-1:0] rxData,
  output logic              rxEmpty,
  input  logic              ovrClr,
  output logic              ovrFlag,
  output logic              txHalfIrq,
  output logic              rxHalfIrq,
  output logic              sckOut,
  input  logic              sckIn,
  output logic              txdOut,
  input  logic              rxdIn,
  output logic              txFsOut,
  input  logic              txFsIn,
  output logic              rxFsOut,
  input  logic              rxFsIn,
  output logic              serOe
);
  localparam int MIN_HALF = (SYS_HZ + 2 * MAX_SCK_HZ - 1) / (2 * MAX_SCK_HZ);
  localparam int CW       = $clog2(DEPTH) + 1;

  sspStrobes_t   st;
  logic          txEmpty;
  logic [CW-1:0] txCnt, rxCnt;

  assign serOe = masterMode;

  ssp_ctrl #(.DIVW(DIVW), .MIN_HALF(MIN_HALF)) ctrl_i (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .rxEn(rxEn),
    .clkDiv(clkDiv), .txEmpty(txEmpty), .sckIn(sckIn), .txFsIn(txFsIn),
    .rxFsIn(rxFsIn), .st(st), .sckOut(sckOut), .txFsOut(txFsOut),
    .rxFsOut(rxFsOut)
  );

  ssp_datapath #(.DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .st(st), .txPush(txPush), .txData(txData),
    .rxPop(rxPop), .ovrClr(ovrClr), .rxdIn(rxdIn), .txdOut(txdOut),
    .rxData(rxData), .txFull(txFull), .txEmpty(txEmpty), .rxEmpty(rxEmpty),
    .txCnt(txCnt), .rxCnt(rxCnt), .ovrFlag(ovrFlag),
    .txHalfIrq(txHalfIrq), .rxHalfIrq(rxHalfIrq)
  );
endmodule

// File: rtl/ssp_chk.sv
module ssp_chk #(
  parameter int DEPTH    = 16,
  parameter int MIN_HALF = 4,
  parameter int CW       = 5
) (
  input logic          clk,
  input logic          rstN,
  input logic          masterMode,
  input logic          sckOut,
  input logic          txFsOut,
  input logic          rxFsOut,
  input logic          ovrFlag,
  input logic [CW-1:0] txCnt,
  input logic [CW-1:0] rxCnt
);
  logic [15:0] gap;
  logic        sckSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gap     <= 16'hFFFF;
      sckSeen <= 1'b0;
    end else begin
      sckSeen <= sckOut;
      if (sckOut != sckSeen)  gap <= '0;
      else if (gap != 16'hFFFF) gap <= gap + 1'b1;
    end
  end

  // R3
  clk_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && (sckOut != sckSeen)) |-> (gap >= 16'(MIN_HALF - 1)));

  // R1
  idle_sck_chk: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && !txFsOut) |-> !sckOut);

  // R1
  no_empty_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && $rose(txFsOut)) |-> ($past(txCnt) != '0));

  // R8
  rx_fs_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxFsOut |-> txFsOut);

  // R7
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrFlag) |-> ($past(rxCnt) == CW'(DEPTH)));

  // R4
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxCnt <= CW'(DEPTH)) && (txCnt <= CW'(DEPTH)));

  // R9
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |-> (!sckOut && !txFsOut && !rxFsOut));
endmodule

bind dual_fifo_ssp ssp_chk #(.DEPTH(DEPTH), .MIN_HALF(MIN_HALF), .CW(CW)) chk_i (
  .clk(clk), .rstN(rstN), .masterMode(masterMode), .sckOut(sckOut),
  .txFsOut(txFsOut), .rxFsOut(rxFsOut), .ovrFlag(ovrFlag),
  .txCnt(txCnt), .rxCnt(rxCnt)
);

// File: tb/dual_fifo_ssp_tb_top.sv
module dual_fifo_ssp_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {clkDiv, word}
  localparam logic [23:0] VECS [NVEC] = '{
    {8'd4, 16'hA5C3}, {8'd5, 16'h0001}, {8'd4, 16'h8000},
    {8'd6, 16'hFFFF}, {8'd2, 16'h1234}, {8'd4, 16'h0000}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic masterMode = 1'b0, rxEn = 1'b0, txPush = 1'b0, rxPop = 1'b0, ovrClr = 1'b0;
  logic [7:0] clkDiv = 8'd4;
  logic [15:0] txData = '0;
  logic sckIn = 1'b0, txFsIn = 1'b0, rxFsIn = 1'b0, rxdDrv = 1'b0, loopBack = 1'b0;
  logic txFull, rxEmpty, ovrFlag, txHalfIrq, rxHalfIrq;
  logic sckOut, txdOut, txFsOut, rxFsOut, serOe, rxdIn;
  logic [15:0] rxData;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  assign rxdIn = loopBack ? txdOut : rxdDrv;
  always #(CLK_PERIOD / 2) clk = ~clk;

  dual_fifo_ssp dut_i (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .rxEn(rxEn), .clkDiv(clkDiv),
    .txPush(txPush), .txData(txData), .txFull(txFull), .rxPop(rxPop), .rxData(rxData),
    .rxEmpty(rxEmpty), .ovrClr(ovrClr), .ovrFlag(ovrFlag), .txHalfIrq(txHalfIrq),
    .rxHalfIrq(rxHalfIrq), .sckOut(sckOut), .sckIn(sckIn), .txdOut(txdOut),
    .rxdIn(rxdIn), .txFsOut(txFsOut), .txFsIn(txFsIn), .rxFsOut(rxFsOut),
    .rxFsIn(rxFsIn), .serOe(serOe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pushWord(input logic [15:0] w);
    @(negedge clk); txPush = 1'b1; txData = w;
    @(negedge clk); txPush = 1'b0;
  endtask

  task automatic popWord(output logic [15:0] w);
    @(negedge clk); w = rxData; rxPop = 1'b1;
    @(negedge clk); rxPop = 1'b0;
  endtask

  task automatic capMaster(output logic [15:0] w, output bit sawRxFs);
    int n = 0;
    logic prev = sckOut;
    w = '0; sawRxFs = 1'b0;
    while (n < 16) begin
      @(negedge clk);
      if (rxFsOut) sawRxFs = 1'b1;
      if (sckOut && !prev) begin w[15 - n] = txdOut; n++; end
      prev = sckOut;
    end
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (txFsOut) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic slaveFrame(input bit doTx, input bit doRx, input logic [15:0] rw,
                            output logic [15:0] cap);
    cap = '0;
    @(negedge clk); txFsIn = doTx; rxFsIn = doRx;
    repeat (12) @(negedge clk);
    for (int i = 15; i >= 0; i--) begin
      rxdDrv = rw[i];
      repeat (10) @(negedge clk);
      cap[i] = txdOut;
      sckIn = 1'b1;
      repeat (10) @(negedge clk);
      sckIn = 1'b0;
    end
    repeat (10) @(negedge clk);
    txFsIn = 1'b0; rxFsIn = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    logic [15:0] w, got;
    bit sawRx;
    int n, hi;
    logic prev;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    chk(!sckOut && !txFsOut && !rxFsOut && !txdOut, "R1 reset serial idle", {sckOut, txFsOut, rxFsOut, txdOut}, 0);
    chk(rxEmpty && !ovrFlag, "R7 reset rx empty no overrun", {rxEmpty, ovrFlag}, 2'b10);
    chk(txHalfIrq && !rxHalfIrq, "R5 R6 reset irqs", {txHalfIrq, rxHalfIrq}, 2'b10);
    chk(!serOe, "R9 slave pins are inputs", serOe, 0);

    // R1: idle master with empty FIFO sends nothing
    masterMode = 1'b1; rxEn = 1'b1; loopBack = 1'b1;
    @(negedge clk);
    chk(serOe, "R9 master drives pins", serOe, 1);
    n = 0; prev = sckOut;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (sckOut != prev || txFsOut) n++;
      prev = sckOut;
    end
    chk(n == 0, "R1 no dummy frame when tx empty", n, 0);

    // vector table: master loopback
    for (int v = 0; v < NVEC; v++) begin
      clkDiv = VECS[v][23:16];
      pushWord(VECS[v][15:0]);
      capMaster(got, sawRx);
      chk(got == VECS[v][15:0], "R2 master word msb first", got, VECS[v][15:0]);
      chk(sawRx, "R8 rx frame sync with rxEn", sawRx, 1);
      waitIdle();
      chk(!rxEmpty, "R8 loopback word stored", rxEmpty, 0);
      popWord(w);
      chk(w == VECS[v][15:0], "R4 rx fifo word", w, VECS[v][15:0]);
    end

    // R4: back-to-back frames in push order
    clkDiv = 8'd4;
    @(negedge clk); txPush = 1'b1; txData = 16'h1111;
    @(negedge clk); txData = 16'h2222;
    @(negedge clk); txData = 16'h3333;
    @(negedge clk); txPush = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      capMaster(got, sawRx);
      chk(got == 16'(k * 16'h1111), "R4 back-to-back order", got, k * 16'h1111);
    end
    waitIdle();
    for (int k = 1; k <= 3; k++) begin
      popWord(w);
      chk(w == 16'(k * 16'h1111), "R4 rx order", w, k * 16'h1111);
    end

    // R3: clock floor and programmed half period, R8 no receive with rxEn low
    rxEn = 1'b0;
    for (int t = 0; t < 2; t++) begin
      clkDiv = (t == 0) ? 8'd1 : 8'd7;
      pushWord(16'h5A5A);
      @(negedge clk);
      while (!sckOut) @(negedge clk);
      hi = 0;
      while (sckOut) begin hi++; @(negedge clk); end
      chk(hi == ((t == 0) ? 4 : 7), "R3 half period", hi, (t == 0) ? 4 : 7);
      sawRx = 1'b0;
      while (txFsOut) begin if (rxFsOut) sawRx = 1'b1; @(negedge clk); end
      repeat (10) @(negedge clk);
      chk(!sawRx && rxEmpty, "R8 rxEn low nothing received", {sawRx, rxEmpty}, 2'b01);
    end

    // slave mode: R5 thresholds
    masterMode = 1'b0; loopBack = 1'b0; clkDiv = 8'd4;
    @(negedge clk);
    chk(!serOe, "R9 slave releases pins", serOe, 0);
    for (int k = 0; k < 8; k++) pushWord(16'h1000 + 16'(k));
    @(negedge clk);
    chk(txHalfIrq, "R5 tx irq at 8 words", txHalfIrq, 1);
    pushWord(16'h1008);
    @(negedge clk);
    chk(!txHalfIrq, "R5 tx irq low at 9 words", txHalfIrq, 0);

    // R9: slave transmit drains in order
    for (int k = 0; k < 9; k++) begin
      slaveFrame(1'b1, 1'b0, 16'h0, got);
      chk(got == 16'h1000 + 16'(k), "R9 slave tx word", got, 16'h1000 + k);
      if (k == 0) chk(txHalfIrq, "R5 tx irq back at 8", txHalfIrq, 1);
    end
    chk(rxEmpty, "R9 tx-only frames receive nothing", rxEmpty, 1);

    // R6 R7: slave receive-only frames, fill and overrun
    for (int k = 0; k < 17; k++) begin
      slaveFrame(1'b0, 1'b1, 16'hC000 + 16'(k), got);
      if (k == 0) chk(got == 16'h0, "R9 rx-only frame keeps txd low", got, 0);
      if (k == 6) chk(!rxHalfIrq, "R6 rx irq low at 7", rxHalfIrq, 0);
      if (k == 7) chk(rxHalfIrq, "R6 rx irq at 8", rxHalfIrq, 1);
      if (k == 15) chk(!ovrFlag, "R7 no overrun at exactly full", ovrFlag, 0);
    end
    chk(ovrFlag, "R7 overrun set", ovrFlag, 1);
    for (int k = 0; k < 16; k++) begin
      popWord(w);
      chk(w == 16'hC000 + 16'(k), "R7 stored words intact", w, 16'hC000 + k);
    end
    @(negedge clk);
    chk(rxEmpty && ovrFlag, "R7 dropped word absent, flag sticky", {rxEmpty, ovrFlag}, 2'b11);
    @(negedge clk); ovrClr = 1'b1;
    @(negedge clk); ovrClr = 1'b0;
    @(negedge clk);
    chk(!ovrFlag, "R7 overrun cleared", ovrFlag, 0);

    // R9: full-duplex slave frame
    pushWord(16'h6E91);
    slaveFrame(1'b1, 1'b1, 16'h3C0F, got);
    chk(got == 16'h6E91, "R9 duplex tx", got, 16'h6E91);
    popWord(w);
    chk(w == 16'h3C0F, "R9 duplex rx", w, 16'h3C0F);
    chk(!sckOut && !txFsOut && !rxFsOut, "R9 slave outputs low", {sckOut, txFsOut, rxFsOut}, 0);

    finishRun();
  end
endmodule